// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block moves outgoing data fragments from memory to a byte stream. Software keeps a ring of two-word transmit descriptors in memory and a matching ring of one-word completion records. Each descriptor gives a buffer address and a control word. The control word holds the fragment length minus one, a flag that marks the last fragment of a frame, and a flag that requests a completion interrupt. Software tells the block how much work is queued by writing a produce index. The block holds its own consume index and follows the produce index around the ring.

For each queued descriptor the block reads its two words. It then fetches the buffer one byte per memory read, in ascending address order and at any byte alignment, and presents each byte on the output stream. A frame may span several consecutive descriptors, and end-of-packet marks only the final byte of a last fragment. When a fragment is done, the block writes a completion word into the record ring and moves the consume index forward. After the index value held in the ring-size register it wraps to zero. Three latched interrupt causes are cleared by writing 1 to them. Each cause has an enable bit, and the enable bits gate only the interrupt line.

The memory port is a single request port with a fixed read latency of one cycle and no stall. Read data returns in the cycle after the request.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset, every register and the consume index are zero, the interrupt causes and the interrupt line are low, and no memory request is issued while the consume index equals the produce index.
- R2: Register writes decode the offset as follows. 0 sets the descriptor ring base and 1 sets the record ring base; both have their low two bits forced to zero. 2 sets the ring size minus one. 3 sets the produce index. 4 sets the interrupt enables. 5 clears the interrupt causes where the written bits are 1.
- R3: For descriptor index i, the block reads the buffer address at descriptor base + 8·i and then the control word at descriptor base + 8·i + 4. Control bits [10:0] hold the length minus one, bit 31 is the last flag and bit 30 is the interrupt flag. The block then emits length+1 bytes starting at the buffer address, where byte lane k of a little-endian memory word is address bits [1:0] = k.
- R4: End-of-packet is high on the final byte of a fragment whose last flag is set, and low on every other byte.
- R5: When a fragment completes, the block writes the word {1, last flag, 19 zeros, length field} to record base + 4·i. The write is in the same cycle as the fragment's final output byte.
- R6: The consume index goes up by one per completed fragment. After the value equal to ring size minus one, it wraps to 0.
- R7: The block processes descriptors until the consume index equals the produce index, and then issues no further memory requests.
- R8: Interrupt cause bit 0 latches when a fragment with the interrupt flag set completes. Bit 1 latches when a last-flag fragment completes. Bit 2 latches when a completion leaves the consume index equal to the produce index. If a new cause is raised in the same cycle as a write-1 clear, the set wins.
- R9: The interrupt line is the OR of (cause AND enable). Writing the enables never changes the latched causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (record word) |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_eop | output | 1 | Final byte of a frame |
| cons_idx | output | 8 | Current consume index |
| irq_stat | output | 3 | Latched interrupt causes |
| irq | output | 1 | Masked interrupt line |

## Verification
A completion can latch interrupt causes in the same clock edge that software performs a write-1 clear of those causes. The bench provokes this by watching for the record write, which is the last cycle of a fragment. In that cycle it drives a clear of all three causes, so both actions land on one edge. The fragment used has the interrupt flag set and no last flag. After the edge, the causes it raises must remain set. The cause that was latched earlier and not raised again must be gone.

// File: rtl/txr_pkg.sv
package txr_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PTR  = 3'd1,
        S_CTL  = 3'd2,
        S_CTLW = 3'd3,
        S_STRM = 3'd4,
        S_STAT = 3'd5
    } fstate_e;

    localparam int CTL_LAST  = 31;
    localparam int CTL_IEN   = 30;

    localparam int NIRQ      = 3;
    localparam int IRQ_FRAG  = 0;
    localparam int IRQ_FRAME = 1;
    localparam int IRQ_DRAIN = 2;

    localparam logic [2:0] RA_DESC = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_SIZE = 3'd2;
    localparam logic [2:0] RA_PROD = 3'd3;
    localparam logic [2:0] RA_EN   = 3'd4;
    localparam logic [2:0] RA_CLR  = 3'd5;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      desc_base,
    output logic [31:0]      stat_base,
    output logic [IDX_W-1:0] ring_last,
    output logic [IDX_W-1:0] prod_idx,
    output logic [NIRQ-1:0]  irq_en,
    output logic             clr_we,
    output logic [NIRQ-1:0]  clr_mask
);
    typedef struct packed {
        logic [31:0]      desc;
        logic [31:0]      stat;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] prod;
        logic [NIRQ-1:0]  en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                RA_DESC: r_d.desc = {reg_wdata[31:2], 2'b00};
                RA_STAT: r_d.stat = {reg_wdata[31:2], 2'b00};
                RA_SIZE: r_d.last = reg_wdata[IDX_W-1:0];
                RA_PROD: r_d.prod = reg_wdata[IDX_W-1:0];
                RA_EN:   r_d.en   = reg_wdata[NIRQ-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign desc_base = r_q.desc;
    assign stat_base = r_q.stat;
    assign ring_last = r_q.last;
    assign prod_idx  = r_q.prod;
    assign irq_en    = r_q.en;
    assign clr_we    = reg_we && (reg_addr == RA_CLR);
    assign clr_mask  = reg_wdata[NIRQ-1:0];
endmodule

// File: rtl/txr_irq.sv
module txr_irq
    import txr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] set_i,
    input  logic            clr_we_i,
    input  logic [NIRQ-1:0] clr_mask_i,
    input  logic [NIRQ-1:0] en_i,
    output logic [NIRQ-1:0] stat_o,
    output logic            irq_o
);
    logic [NIRQ-1:0] stat_d, stat_q;

    always_comb begin
        for (int i = 0; i < NIRQ; i++) begin
            stat_d[i] = set_i[i] | (stat_q[i] & ~(clr_we_i & clr_mask_i[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & en_i);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

    assert_stat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && !clr_we_i) |=> (stat_q == $past(stat_q)));
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
    import txr_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      desc_base,
    input  logic [31:0]      stat_base,
    input  logic [IDX_W-1:0] ring_last,
    input  logic [IDX_W-1:0] prod_idx,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_eop,
    output logic [IDX_W-1:0] cons_idx,
    output logic [NIRQ-1:0]  ev_set
);
    localparam int PADW = 30 - LEN_W;

    typedef struct packed {
        fstate_e          st;
        logic [IDX_W-1:0] cons;
        logic [31:0]      bufa;
        logic [LEN_W-1:0] len;
        logic             last;
        logic             ien;
        logic [LEN_W-1:0] cnt;
        logic             pend;
        logic [1:0]       lane;
        logic             peop;
    } fs_t;

    fs_t f_d, f_q;
    logic [31:0]      byte_addr;
    logic [IDX_W-1:0] cons_nx;

    assign byte_addr = f_q.bufa + 32'(f_q.cnt);
    assign cons_nx   = (f_q.cons == ring_last) ? '0 : f_q.cons + 1'b1;

    always_comb begin
        f_d       = f_q;
        f_d.pend  = 1'b0;
        f_d.peop  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ev_set    = '0;
        case (f_q.st)
            S_IDLE: begin
                if (f_q.cons != prod_idx) f_d.st = S_PTR;
            end
            S_PTR: begin
                mem_req  = 1'b1;
                mem_addr = desc_base + (32'(f_q.cons) << 3);
                f_d.st   = S_CTL;
            end
            S_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc_base + (32'(f_q.cons) << 3) + 32'd4;
                f_d.bufa = mem_rdata;
                f_d.st   = S_CTLW;
            end
            S_CTLW: begin
                f_d.len  = mem_rdata[LEN_W-1:0];
                f_d.last = mem_rdata[CTL_LAST];
                f_d.ien  = mem_rdata[CTL_IEN];
                f_d.cnt  = '0;
                f_d.st   = S_STRM;
            end
            S_STRM: begin
                mem_req  = 1'b1;
                mem_addr = {byte_addr[31:2], 2'b00};
                f_d.pend = 1'b1;
                f_d.lane = byte_addr[1:0];
                f_d.peop = f_q.last && (f_q.cnt == f_q.len);
                if (f_q.cnt == f_q.len) f_d.st = S_STAT;
                else                    f_d.cnt = f_q.cnt + 1'b1;
            end
            S_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_base + (32'(f_q.cons) << 2);
                mem_wdata = {1'b1, f_q.last, {PADW{1'b0}}, f_q.len};
                ev_set[IRQ_FRAG]  = f_q.ien;
                ev_set[IRQ_FRAME] = f_q.last;
                ev_set[IRQ_DRAIN] = (cons_nx == prod_idx);
                f_d.cons  = cons_nx;
                f_d.st    = S_IDLE;
            end
            default: f_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign out_valid = f_q.pend;
    assign out_byte  = 8'(mem_rdata >> {f_q.lane, 3'b000});
    assign out_eop   = f_q.peop;
    assign cons_idx  = f_q.cons;

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_idx != $past(cons_idx)) |->
            ((cons_idx == $past(cons_idx) + 1'b1) || (cons_idx == '0)));

    assert_record_with_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> out_valid);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == S_STRM) |-> (f_q.cnt <= f_q.len));
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
    import txr_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_eop,
    output logic [IDX_W-1:0] cons_idx,
    output logic [NIRQ-1:0]  irq_stat,
    output logic             irq
);
    logic [31:0]      desc_base, stat_base;
    logic [IDX_W-1:0] ring_last, prod_idx;
    logic [NIRQ-1:0]  irq_en, clr_mask, ev_set;
    logic             clr_we;

    txr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .desc_base(desc_base), .stat_base(stat_base),
        .ring_last(ring_last), .prod_idx(prod_idx),
        .irq_en(irq_en), .clr_we(clr_we), .clr_mask(clr_mask)
    );

    txr_fetch #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .desc_base(desc_base), .stat_base(stat_base),
        .ring_last(ring_last), .prod_idx(prod_idx),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_byte(out_byte), .out_eop(out_eop),
        .cons_idx(cons_idx), .ev_set(ev_set)
    );

    txr_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_i(ev_set), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
        .en_i(irq_en), .stat_o(irq_stat), .irq_o(irq)
    );
endmodule

// File: tb/sim_tx_ring_dma.sv
`timescale 1ns/1ps
module sim_tx_ring_dma;
    localparam int DB = 32'h100;
    localparam int SB = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, out_eop;
    logic [7:0]  out_byte;
    logic [7:0]  cons_idx;
    logic [2:0]  irq_stat;
    logic        irq;

    always #2.5 clk = ~clk;

    tx_ring_dma u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_byte(out_byte), .out_eop(out_eop),
        .cons_idx(cons_idx), .irq_stat(irq_stat), .irq(irq)
    );

    logic [31:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    int n_run = 0;
    int n_fail = 0;
    logic [8:0] exp_q[$];

    // reference stream model: each valid byte is compared against the queue
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            logic [8:0] e;
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R7 unexpected byte act=%h exp=none", out_byte);
            end else begin
                e = exp_q.pop_front();
                if ({out_eop, out_byte} !== e) begin
                    n_fail++;
                    $display("FAIL R3 R4 stream act=%h exp=%h", {out_eop, out_byte}, e);
                end
            end
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_desc(input int idx, input int bufa, input int len,
                            input bit last, input bit ien);
        mem[(DB >> 2) + idx * 2]     = 32'(bufa);
        mem[(DB >> 2) + idx * 2 + 1] = {last, ien, 19'd0, 11'(len)};
        for (int i = 0; i <= len; i++)
            exp_q.push_back({last && (i == len), pat(bufa + i)});
    endtask

    function automatic logic [31:0] rec(input int len, input bit last);
        return {1'b1, last, 19'd0, 11'(len)};
    endfunction

    task automatic wait_cons(input logic [7:0] target);
        int k = 0;
        while (cons_idx !== target && k < 2000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 2000) begin
            n_fail++;
            $display("FAIL R7 consume wait act=%h exp=%h", cons_idx, target);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int reqs;
        int k;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int w = 0; w < 1024; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        for (int w = SB >> 2; w < (SB >> 2) + 8; w++) mem[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and idle while produce equals consume
        reqs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk("R1 no request when empty", 32'(reqs), 0);
        chk("R1 consume index", 32'(cons_idx), 0);
        chk("R1 causes", 32'(irq_stat), 0);
        chk("R1 irq line", 32'(irq), 0);

        // R2 setup: bases, ring of four
        wr(3'd0, DB | 32'h3);
        wr(3'd1, SB);
        wr(3'd2, 3);

        // two-fragment frame, unaligned payload
        set_desc(0, 32'h300, 7, 1'b0, 1'b0);
        set_desc(1, 32'h403, 11, 1'b1, 1'b1);
        wr(3'd3, 2);
        wait_cons(2);
        chk("R3 R4 all bytes seen", 32'(exp_q.size()), 0);
        chk("R5 record 0", mem[(SB >> 2) + 0], rec(7, 1'b0));
        chk("R5 record 1", mem[(SB >> 2) + 1], rec(11, 1'b1));
        chk("R6 consume after two", 32'(cons_idx), 2);
        chk("R8 causes after frame", 32'(irq_stat), 3'b111);
        chk("R9 line masked", 32'(irq), 0);

        wr(3'd4, 7);
        chk("R9 enable keeps causes", 32'(irq_stat), 3'b111);
        chk("R9 line on", 32'(irq), 1);
        wr(3'd5, 1);
        chk("R8 clear bit0", 32'(irq_stat), 3'b110);
        wr(3'd5, 6);
        chk("R8 clear rest", 32'(irq_stat), 0);
        chk("R9 line off", 32'(irq), 0);
        wr(3'd4, 0);

        // R6 wrap: indices 2,3,0 including a one-byte fragment
        set_desc(2, 32'h500, 0, 1'b1, 1'b0);
        set_desc(3, 32'h601, 2, 1'b0, 1'b0);
        set_desc(0, 32'h702, 4, 1'b1, 1'b0);
        wr(3'd3, 1);
        wait_cons(1);
        chk("R3 R4 wrap bytes seen", 32'(exp_q.size()), 0);
        chk("R5 record 2", mem[(SB >> 2) + 2], rec(0, 1'b1));
        chk("R5 record 3", mem[(SB >> 2) + 3], rec(2, 1'b0));
        chk("R5 record 0 rewritten", mem[(SB >> 2) + 0], rec(4, 1'b1));
        chk("R6 consume wrapped", 32'(cons_idx), 1);
        chk("R8 causes without flag", 32'(irq_stat), 3'b110);

        // R8 concurrency: clear-all lands on the completion edge
        set_desc(1, 32'h380, 3, 1'b0, 1'b1);
        wr(3'd3, 2);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!mem_we && k < 200);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h7;
        @(negedge clk);
        reg_we = 1'b0;
        wait_cons(2);
        chk("R8 set beats clear", 32'(irq_stat), 3'b101);
        chk("R5 record 1 rewritten", mem[(SB >> 2) + 1], rec(3, 1'b0));
        chk("R4 no eop stream done", 32'(exp_q.size()), 0);

        // R7: idle after draining
        reqs = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk("R7 quiet when drained", 32'(reqs), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule